// File: doc/BRIEF.md
# Serial Control Register Interface

This block is a three-wire serial slave (active-low select, serial clock, serial data in) that lets a host load the control state of a mixed-signal front end. Each transaction carries one 16-bit word. The first twelve bits sent are the data payload and the last four bits are the target address. A word therefore cannot be routed until its final bit has arrived, and it is acted on only when the select line is released.

The three serial lines run asynchronously to the system clock. They are brought into the system clock domain by two-flop synchronizers, and the serial clock is edge-detected after synchronization. Decoded words update a small register bank: a main enable word, a short enable word, three 12-bit auxiliary DAC values, two 6-bit offset trims, a 2-bit common-mode select and a 3-bit wake-up mode. A write to the auxiliary ADC address produces a start pulse instead of a stored value. All fields are presented in parallel to a power-mode controller.

Top module: `sctl_top`

## Requirements
- R1: A word is sent most significant bit first, with one bit sampled on each rising edge of `sclk` while `cs_n` is low. The first 12 bits form the data field `data[11:0]` (bit 11 is sent first). The last 4 bits form the address `addr[3:0]` (bit 0 is sent last).
- R2: A word takes effect only when `cs_n` rises after exactly 16 rising `sclk` edges. A frame of 15 or 17 bits changes no output, and neither do `sclk` edges while `cs_n` is high.
- R3: The address codes are: 0 main enable, 1/2/3 auxiliary DAC 1/2/3, 4 I offset, 5 Q offset, 6 common-mode select, 7 auxiliary ADC start, 8 short enable, 9 wake-up select. Writes to codes 10 to 15 change no output.
- R4: In the main enable word only bits 4, 5, 6 and 9 are kept. `aux_dac_en` is {bit6, bit5, bit4} and `aux_adc_en` is bit 9. On `en_main` every other bit reads as zero, including the reserved bits 11:10.
- R5: `dac1`, `dac2`, `dac3` and `en_short` take all 12 data bits. `i_offset` and `q_offset` take `data[5:0]`, `cm_sel` takes `data[1:0]` and `wake_sel` takes `data[2:0]`.
- R6: A write to address 7 raises `adc_start` for exactly one system clock and changes no other output.
- R7: After reset every output is zero, and `use_short` is 0, so the main enable word is the active enable source.
- R8: A write to address 8 sets `use_short` to 1. A write to address 0 clears it to 0.
- R9: The interface keeps accepting writes whatever the register contents are, including when all enable bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Serial select, active low, asynchronous |
| sclk | input | 1 | Serial clock, asynchronous |
| sdi | input | 1 | Serial data in, asynchronous |
| en_main | output | 12 | Main enable word, with only bits 4, 5, 6 and 9 kept |
| aux_dac_en | output | 3 | Auxiliary DAC enables {DAC3, DAC2, DAC1} |
| aux_adc_en | output | 1 | Auxiliary ADC enable |
| en_short | output | 12 | Short enable word |
| use_short | output | 1 | 1 when the short enable word was written last |
| dac1 | output | 12 | Auxiliary DAC 1 value |
| dac2 | output | 12 | Auxiliary DAC 2 value |
| dac3 | output | 12 | Auxiliary DAC 3 value |
| i_offset | output | 6 | I channel offset trim |
| q_offset | output | 6 | Q channel offset trim |
| cm_sel | output | 2 | Common-mode select |
| wake_sel | output | 3 | Wake-up mode select |
| adc_start | output | 1 | One-cycle auxiliary ADC start pulse |

## Verification
The hardest case to reach is a frame whose bit count is wrong: its payload must leave no trace even though every bit was shifted in correctly. The bench sends 15-bit and 17-bit frames that carry a valid address and fresh data. It also toggles `sclk` while `cs_n` is high. After each of these it checks that every output still matches the model. The main address sweep covers all 16 address codes with several computed data patterns. This exercises the unused codes, the bit masking in the main enable word, and the switching of the active enable source between the main and short words.

// File: rtl/sctl_pkg.sv
// Package: shared widths and address codes for the serial control interface.
// Assumes a 16-bit frame made of a 12-bit data field followed by a 4-bit address.
package sctl_pkg;
    localparam int DATA_W  = 12;
    localparam int ADDR_W  = 4;
    localparam int FRAME_W = DATA_W + ADDR_W;
    localparam int OFF_W   = 6;
    localparam int CM_W    = 2;
    localparam int WAKE_W  = 3;

    localparam logic [ADDR_W-1:0] A_MAIN  = 4'd0;
    localparam logic [ADDR_W-1:0] A_DAC1  = 4'd1;
    localparam logic [ADDR_W-1:0] A_DAC2  = 4'd2;
    localparam logic [ADDR_W-1:0] A_DAC3  = 4'd3;
    localparam logic [ADDR_W-1:0] A_IOFF  = 4'd4;
    localparam logic [ADDR_W-1:0] A_QOFF  = 4'd5;
    localparam logic [ADDR_W-1:0] A_CM    = 4'd6;
    localparam logic [ADDR_W-1:0] A_ADC   = 4'd7;
    localparam logic [ADDR_W-1:0] A_SHORT = 4'd8;
    localparam logic [ADDR_W-1:0] A_WAKE  = 4'd9;

    // Main enable bits that are kept; all other bits read as zero.
    localparam logic [DATA_W-1:0] MAIN_KEEP = 12'h270;
endpackage

// File: rtl/sctl_sync.sv
// Module: brings the three asynchronous serial lines into the clk domain
// and detects rising edges of the synchronized serial clock.
// Assumes each serial level stays stable for at least two clk cycles.
module sctl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk,
    input  logic sdi,
    output logic cs_s,
    output logic sclk_rise,
    output logic sdi_s
);
    localparam int LINES = 3;
    localparam logic [LINES-1:0] IDLE = 3'b001;   // {sdi, sclk, cs_n}

    logic [LINES-1:0] raw;
    logic [LINES-1:0] synced;
    logic             sclk_d;

    assign raw = {sdi, sclk, cs_n};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain;
        // Shift the line through its synchronizer chain.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= {STAGES{IDLE[g]}};
            else        chain <= {chain[STAGES-2:0], raw[g]};
        end
        assign synced[g] = chain[STAGES-1];
    end

    // Keep the previous synchronized serial clock for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_d <= 1'b0;
        else        sclk_d <= synced[1];
    end

    assign cs_s      = synced[0];
    assign sdi_s     = synced[2];
    assign sclk_rise = synced[1] & ~sclk_d;
endmodule

// File: rtl/sctl_shift.sv
// Module: collects serial bits into a frame and flags a complete one when
// select is released after exactly FRAME_W bits. Other counts are dropped.
// Assumes synchronized inputs from sctl_sync.
module sctl_shift
    import sctl_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs_s,
    input  logic               sclk_rise,
    input  logic               sdi_s,
    output logic               frame_valid,
    output logic [FRAME_W-1:0] frame
);
    localparam int CNT_MAX = FRAME_W + 1;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    logic [CNT_W-1:0]   cnt;
    logic [FRAME_W-1:0] sreg;
    logic               cs_d;

    // Count bits in the frame; clear while deselected, saturate past a full frame.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_s)                         cnt <= '0;
        else if (sclk_rise && cnt != CNT_W'(CNT_MAX)) cnt <= cnt + 1'b1;
    end

    // Shift serial data in, most significant bit first.
    always_ff @(posedge clk) begin
        if (!rst_n)                 sreg <= '0;
        else if (!cs_s && sclk_rise) sreg <= {sreg[FRAME_W-2:0], sdi_s};
    end

    // Flag a complete frame one cycle after select is released.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_d        <= 1'b1;
            frame_valid <= 1'b0;
        end else begin
            cs_d        <= cs_s;
            frame_valid <= cs_s && !cs_d && (cnt == CNT_W'(FRAME_W));
        end
    end

    assign frame = sreg;

    // R2
    valid_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |-> cs_s);
    // R2
    bad_count_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cs_s) && cnt != CNT_W'(FRAME_W)) |=> !frame_valid);
endmodule

// File: rtl/sctl_regs.sv
// Module: decodes a completed frame and updates the control register bank.
// Assumes frame_valid is a single-cycle strobe with frame stable alongside.
module sctl_regs
    import sctl_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_valid,
    input  logic [FRAME_W-1:0] frame,
    output logic [DATA_W-1:0]  en_main,
    output logic [DATA_W-1:0]  en_short,
    output logic               use_short,
    output logic [DATA_W-1:0]  dac1,
    output logic [DATA_W-1:0]  dac2,
    output logic [DATA_W-1:0]  dac3,
    output logic [OFF_W-1:0]   i_offset,
    output logic [OFF_W-1:0]   q_offset,
    output logic [CM_W-1:0]    cm_sel,
    output logic [WAKE_W-1:0]  wake_sel,
    output logic               adc_start
);
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;

    assign addr = frame[ADDR_W-1:0];
    assign data = frame[FRAME_W-1:ADDR_W];

    // Write the addressed register and generate the ADC start strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_main   <= '0;
            en_short  <= '0;
            use_short <= 1'b0;
            dac1      <= '0;
            dac2      <= '0;
            dac3      <= '0;
            i_offset  <= '0;
            q_offset  <= '0;
            cm_sel    <= '0;
            wake_sel  <= '0;
            adc_start <= 1'b0;
        end else begin
            adc_start <= frame_valid && (addr == A_ADC);
            if (frame_valid) begin
                case (addr)
                    A_MAIN:  begin en_main  <= data & MAIN_KEEP; use_short <= 1'b0; end
                    A_SHORT: begin en_short <= data;             use_short <= 1'b1; end
                    A_DAC1:  dac1     <= data;
                    A_DAC2:  dac2     <= data;
                    A_DAC3:  dac3     <= data;
                    A_IOFF:  i_offset <= data[OFF_W-1:0];
                    A_QOFF:  q_offset <= data[OFF_W-1:0];
                    A_CM:    cm_sel   <= data[CM_W-1:0];
                    A_WAKE:  wake_sel <= data[WAKE_W-1:0];
                    default: ;
                endcase
            end
        end
    end

    // R6
    adc_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |=> !adc_start);
    // R2
    hold_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_valid |=> ($stable(dac1) && $stable(dac2) && $stable(dac3) && $stable(en_main)));
    // R8
    source_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_valid |=> $stable(use_short));
endmodule

// File: rtl/sctl_top.sv
// Module: serial control register interface top. It chains the synchronizer,
// the frame assembler and the register bank, and derives the enable bits.
// Assumes serial clock phases last at least three clk cycles.
module sctl_top
    import sctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              sdi,
    output logic [DATA_W-1:0] en_main,
    output logic [2:0]        aux_dac_en,
    output logic              aux_adc_en,
    output logic [DATA_W-1:0] en_short,
    output logic              use_short,
    output logic [DATA_W-1:0] dac1,
    output logic [DATA_W-1:0] dac2,
    output logic [DATA_W-1:0] dac3,
    output logic [OFF_W-1:0]  i_offset,
    output logic [OFF_W-1:0]  q_offset,
    output logic [CM_W-1:0]   cm_sel,
    output logic [WAKE_W-1:0] wake_sel,
    output logic              adc_start
);
    logic               cs_s, sclk_rise, sdi_s;
    logic               frame_valid;
    logic [FRAME_W-1:0] frame;

    sctl_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
        .cs_s(cs_s), .sclk_rise(sclk_rise), .sdi_s(sdi_s)
    );

    sctl_shift u_shift (
        .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .sclk_rise(sclk_rise),
        .sdi_s(sdi_s), .frame_valid(frame_valid), .frame(frame)
    );

    sctl_regs u_regs (
        .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid), .frame(frame),
        .en_main(en_main), .en_short(en_short), .use_short(use_short),
        .dac1(dac1), .dac2(dac2), .dac3(dac3),
        .i_offset(i_offset), .q_offset(q_offset), .cm_sel(cm_sel),
        .wake_sel(wake_sel), .adc_start(adc_start)
    );

    // Per-function enables taken from the main enable word.
    assign aux_dac_en = en_main[6:4];
    assign aux_adc_en = en_main[9];

    // R4
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_main[11:10] == 2'b00);
endmodule

// File: tb/test_sctl_top.sv
module test_sctl_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
    logic [11:0] en_main, en_short, dac1, dac2, dac3;
    logic [2:0]  aux_dac_en, wake_sel;
    logic        aux_adc_en, use_short, adc_start;
    logic [5:0]  i_offset, q_offset;
    logic [1:0]  cm_sel;

    int vectors = 0, fails = 0, pulses = 0, wide_pulse = 0;
    logic adc_prev = 1'b0;

    logic [11:0] x_main, x_short, x_d1, x_d2, x_d3;
    logic [5:0]  x_io, x_qo;
    logic [1:0]  x_cm;
    logic [2:0]  x_wk;
    logic        x_use;
    int          x_pulses;

    always #10 clk = ~clk;

    sctl_top i_sctl_top (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
        .en_main(en_main), .aux_dac_en(aux_dac_en), .aux_adc_en(aux_adc_en),
        .en_short(en_short), .use_short(use_short),
        .dac1(dac1), .dac2(dac2), .dac3(dac3),
        .i_offset(i_offset), .q_offset(q_offset), .cm_sel(cm_sel),
        .wake_sel(wake_sel), .adc_start(adc_start)
    );

    // Count start pulses and any pulse lasting more than one cycle.
    always @(negedge clk) begin
        if (adc_start) pulses++;
        if (adc_start && adc_prev) wide_pulse++;
        adc_prev = adc_start;
    end

    task automatic cmp(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        cmp(req, "en_main", 32'(en_main), 32'(x_main));
        cmp("R4", "aux_dac_en", 32'(aux_dac_en), 32'({x_main[6], x_main[5], x_main[4]}));
        cmp("R4", "aux_adc_en", 32'(aux_adc_en), 32'(x_main[9]));
        cmp(req, "en_short", 32'(en_short), 32'(x_short));
        cmp("R8", "use_short", 32'(use_short), 32'(x_use));
        cmp(req, "dac1", 32'(dac1), 32'(x_d1));
        cmp(req, "dac2", 32'(dac2), 32'(x_d2));
        cmp(req, "dac3", 32'(dac3), 32'(x_d3));
        cmp("R5", "i_offset", 32'(i_offset), 32'(x_io));
        cmp("R5", "q_offset", 32'(q_offset), 32'(x_qo));
        cmp("R5", "cm_sel", 32'(cm_sel), 32'(x_cm));
        cmp("R5", "wake_sel", 32'(wake_sel), 32'(x_wk));
        cmp("R6", "adc pulses", 32'(pulses), 32'(x_pulses));
        cmp("R6", "wide pulses", 32'(wide_pulse), 32'd0);
    endtask

    // Model of a committed write, following the requirements.
    task automatic model(input logic [3:0] a, input logic [11:0] d);
        case (a)
            4'd0: begin x_main = d & 12'h270; x_use = 1'b0; end
            4'd1: x_d1 = d;
            4'd2: x_d2 = d;
            4'd3: x_d3 = d;
            4'd4: x_io = d[5:0];
            4'd5: x_qo = d[5:0];
            4'd6: x_cm = d[1:0];
            4'd7: x_pulses++;
            4'd8: begin x_short = d; x_use = 1'b1; end
            4'd9: x_wk = d[2:0];
            default: ;
        endcase
    endtask

    task automatic half;
        repeat (3) @(negedge clk);
    endtask

    // Send nbits of word w, MSB first; bits past 16 are sent as zero.
    task automatic send(input logic [15:0] w, input int nbits);
        cs_n = 1'b0;
        half;
        for (int i = 0; i < nbits; i++) begin
            sdi  = (i < 16) ? w[15-i] : 1'b0;
            half;
            sclk = 1'b1;
            half;
            sclk = 1'b0;
        end
        half;
        cs_n = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    initial begin
        x_main = '0; x_short = '0; x_d1 = '0; x_d2 = '0; x_d3 = '0;
        x_io = '0; x_qo = '0; x_cm = '0; x_wk = '0; x_use = 1'b0; x_pulses = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check_all("R7");

        // R1 R3 R4 R5 R6 R8: sweep all address codes with computed data.
        for (int p = 0; p < 4; p++) begin
            for (int a = 0; a < 16; a++) begin
                logic [11:0] d;
                d = 12'((p * 12'h5A3) ^ (a * 12'h111) ^ (p == 3 ? 12'hFFF : 12'h000));
                send({d, 4'(a)}, 16);
                model(4'(a), d);
                check_all(a >= 10 ? "R3" : "R1");
            end
        end

        // R2: short and long frames are discarded.
        send({12'hABC, 4'd1}, 15);
        check_all("R2");
        send({12'h123, 4'd2}, 17);
        check_all("R2");
        send({12'h456, 4'd0}, 17);
        check_all("R2");

        // R2: serial clocks while deselected have no effect.
        for (int i = 0; i < 16; i++) begin
            sdi = i[0];
            half; sclk = 1'b1; half; sclk = 1'b0;
        end
        repeat (8) @(negedge clk);
        check_all("R2");

        // R8: source toggles between the short and main enable words.
        send({12'hFFF, 4'd8}, 16); model(4'd8, 12'hFFF); check_all("R8");
        send({12'hFFF, 4'd0}, 16); model(4'd0, 12'hFFF); check_all("R4");

        // R9: all enables cleared, writes are still accepted.
        send({12'h000, 4'd0}, 16); model(4'd0, 12'h000);
        send({12'h000, 4'd8}, 16); model(4'd8, 12'h000);
        send({12'h9E1, 4'd3}, 16); model(4'd3, 12'h9E1);
        send({12'h000, 4'd7}, 16); model(4'd7, 12'h000);
        check_all("R9");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule